// File: doc/BRIEF.md
# Multi-Core Clock Divider with Staged Reload

This block derives one clock-enable stream per core from a shared parent clock. Each core has a divide ratio of 1, 2 or 3. The enable is high for one parent cycle out of every N cycles, where N is the ratio that core is currently using. Software uses a word-wide register bus.

To change ratios, software first writes the new ratios into one packed ratio register. It then selects the cores that should take the change with per-core reload-select bits, and finally raises a shared trigger bit. On the rising edge of the trigger, each selected core stages its new ratio. The core adopts that ratio only when its current output period ends, so no period is ever cut short or stretched.

A status word reports the ratio each core is actually using. A per-core hold field stops a core's enables and restarts its count. A fabric ratio field is stored for software and has no effect on the outputs.

Top module: `core_clk_div`

## Requirements
- R1: After reset, the control word (address 0x0) reads 0, the fabric word (0x8) reads 0, the ratio word (0xC) reads 0x01010101, and the status word (0x10) reads 0x01010101, so every core runs at ratio 1.
- R2: A write to 0x0 keeps only bits [15:8], [20+NUM_CORES-1:20] and 24. A write to 0xC keeps only bits [8n+5:8n] for each core n. A write to 0x8 keeps only bits [21:16]. Reads of any other address return 0, and writes to them change nothing.
- R3: Each core's enable is high for exactly one parent cycle in every N cycles, where N is that core's active ratio. With ratio 1 the enable stays high.
- R4: The ratio in field [8n+5:8n] is clamped when it is staged. A value of 0 becomes 1, values 1 to 3 are kept, and values above 3 become 3. The status word reports the clamped value at bits [8n+5:8n].
- R5: A new ratio reaches a core only through a rising edge of control bit 24 while that core's reload-select bit (20+n) is set. Within a few cycles of that edge, the status word shows the new ratio for that core.
- R6: When the trigger rises, a core whose reload-select bit is clear keeps its current ratio.
- R7: While bit 24 stays high, or stays low, changes to the ratio word or to the reload-select bits do not change any active ratio.
- R8: An active ratio changes only at the end of an output period. Every gap between two consecutive enables therefore equals either the old ratio or the new ratio.
- R9: While hold bit (8+n) is set, core n produces no enable and its count is held at the start of a period. A ratio staged for core n is applied at once during the hold.
- R10: The fabric field has no effect on any enable or on the status word.
- R11: The status word at 0x10 is read-only. Writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Parent clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Write strobe for one word |
| bus_addr_i | input | ADDR_W (5) | Byte address of the word |
| bus_wdata_i | input | DATA_W (32) | Write data |
| bus_rdata_o | output | DATA_W (32) | Read data for bus_addr_i, combinational |
| core_en_o | output | NUM_CORES (4) | One clock-enable per core |

## Verification
The bench builds the block with its defaults: four cores, 6-bit ratio fields with an 8-bit stride, and a 32-bit bus. With four cores, every reload-select combination can be applied in random order, and the unselected cores can be checked against their old ratios in the same run. Random ratio values include 0 and values far above 3, so both clamp limits are reached. A wait of a random number of cycles before each trigger moves the trigger to every phase of a ratio-3 period. This lets the gap monitor catch any switch that happens in the middle of a period.

// File: rtl/core_clk_div_pkg.sv
package core_clk_div_pkg;

    // Width of one ratio field in the packed ratio word.
    parameter int CCD_RATIO_W   = 6;
    // Largest ratio a core can use.
    parameter int CCD_MAX_RATIO = 3;
    // Width of a core's period counter and of its active ratio.
    parameter int CCD_CNT_W     = $clog2(CCD_MAX_RATIO + 1);

    // Word addresses on the register bus.
    parameter logic [4:0] CCD_ADDR_CTRL   = 5'h00;
    parameter logic [4:0] CCD_ADDR_FABRIC = 5'h08;
    parameter logic [4:0] CCD_ADDR_RATIO  = 5'h0C;
    parameter logic [4:0] CCD_ADDR_STATUS = 5'h10;

    typedef logic [CCD_CNT_W-1:0] cnt_t;

    // Maps a requested field value onto a ratio the divider can use.
    function automatic cnt_t clamp_ratio(input logic [CCD_RATIO_W-1:0] req);
        if (req == '0)
            return cnt_t'(1);
        else if (req > CCD_RATIO_W'(CCD_MAX_RATIO))
            return cnt_t'(CCD_MAX_RATIO);
        else
            return req[CCD_CNT_W-1:0];
    endfunction

    // State of one core's divider.
    typedef struct packed {
        cnt_t cnt;        // position within the current output period
        cnt_t active;     // ratio in use
        logic pend;       // a staged ratio is waiting for a period boundary
        cnt_t pend_ratio; // the staged ratio
    } div_state_t;

endpackage

// File: rtl/core_clk_div_core.sv
module core_clk_div_core
    import core_clk_div_pkg::*;
(
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   hold_i,
    input  logic                   reload_i,
    input  logic [CCD_RATIO_W-1:0] ratio_i,
    output logic                   en_o,
    output cnt_t                   active_o
);

    div_state_t st_d, st_q;
    logic       terminal;

    assign terminal = (st_q.cnt == st_q.active - cnt_t'(1));
    assign en_o     = !hold_i && terminal;
    assign active_o = st_q.active;

    always_comb begin
        st_d = st_q;
        if (hold_i) begin
            // Held: restart the period and apply any staged ratio at once.
            st_d.cnt = '0;
            if (st_q.pend) begin
                st_d.active = st_q.pend_ratio;
                st_d.pend   = 1'b0;
            end
        end else if (terminal) begin
            // Period boundary: the only point where a ratio may switch.
            st_d.cnt = '0;
            if (st_q.pend) begin
                st_d.active = st_q.pend_ratio;
                st_d.pend   = 1'b0;
            end
        end else begin
            st_d.cnt = st_q.cnt + cnt_t'(1);
        end
        // A reload request is checked last, so a new request is not lost
        // if it arrives in the same cycle as a boundary.
        if (reload_i) begin
            st_d.pend       = 1'b1;
            st_d.pend_ratio = clamp_ratio(ratio_i);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.cnt        <= '0;
            st_q.active     <= cnt_t'(1);
            st_q.pend       <= 1'b0;
            st_q.pend_ratio <= cnt_t'(1);
        end else begin
            st_q <= st_d;
        end
    end

    // The active ratio always lies in the allowed range.
    assert_active_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.active >= cnt_t'(1)) && (st_q.active <= cnt_t'(CCD_MAX_RATIO)));

    // The ratio switches only at a period end or while the core is held.
    assert_switch_at_boundary_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.active != $past(st_q.active)) |->
            ($past(hold_i) || ($past(st_q.cnt) == $past(st_q.active) - cnt_t'(1))));

    // Any change of the active ratio comes from a staged reload.
    assert_switch_needs_stage_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.active != $past(st_q.active)) |-> $past(st_q.pend));

    // Holding a core resets its count to the start of a period.
    assert_hold_restarts_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hold_i |=> (st_q.cnt == '0));

    // An enable pulse lasts one cycle when the ratio exceeds 1 and no switch is staged.
    assert_pulse_width_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_o && (st_q.active > cnt_t'(1)) && !st_q.pend && !reload_i) |=> !en_o);

endmodule

// File: rtl/core_clk_div_regs.sv
module core_clk_div_regs
    import core_clk_div_pkg::*;
#(
    parameter int NUM_CORES    = 4,
    parameter int DATA_W       = 32,
    parameter int ADDR_W       = 5,
    parameter int FIELD_STRIDE = 8,
    parameter int HOLD_LSB     = 8,
    parameter int HOLD_W       = 8,
    parameter int RELOAD_LSB   = 20,
    parameter int TRIG_BIT     = 24,
    parameter int FAB_LSB      = 16
) (
    input  logic                             clk_i,
    input  logic                             rst_ni,
    input  logic                             we_i,
    input  logic [ADDR_W-1:0]                addr_i,
    input  logic [DATA_W-1:0]                wdata_i,
    input  logic [DATA_W-1:0]                status_i,
    output logic [DATA_W-1:0]                rdata_o,
    output logic [NUM_CORES-1:0]             hold_o,
    output logic [NUM_CORES-1:0]             reload_o,
    output logic [NUM_CORES*CCD_RATIO_W-1:0] ratio_o
);

    function automatic logic [DATA_W-1:0] make_ctrl_mask();
        logic [DATA_W-1:0] m = '0;
        for (int i = 0; i < HOLD_W; i++)    m[HOLD_LSB + i]   = 1'b1;
        for (int i = 0; i < NUM_CORES; i++) m[RELOAD_LSB + i] = 1'b1;
        m[TRIG_BIT] = 1'b1;
        return m;
    endfunction

    function automatic logic [DATA_W-1:0] make_ratio_mask();
        logic [DATA_W-1:0] m = '0;
        for (int n = 0; n < NUM_CORES; n++)
            for (int b = 0; b < CCD_RATIO_W; b++) m[n*FIELD_STRIDE + b] = 1'b1;
        return m;
    endfunction

    function automatic logic [DATA_W-1:0] make_ratio_rst();
        logic [DATA_W-1:0] m = '0;
        for (int n = 0; n < NUM_CORES; n++) m[n*FIELD_STRIDE] = 1'b1;
        return m;
    endfunction

    function automatic logic [DATA_W-1:0] make_fab_mask();
        logic [DATA_W-1:0] m = '0;
        for (int b = 0; b < CCD_RATIO_W; b++) m[FAB_LSB + b] = 1'b1;
        return m;
    endfunction

    localparam logic [DATA_W-1:0] CTRL_MASK  = make_ctrl_mask();
    localparam logic [DATA_W-1:0] RATIO_MASK = make_ratio_mask();
    localparam logic [DATA_W-1:0] RATIO_RST  = make_ratio_rst();
    localparam logic [DATA_W-1:0] FAB_MASK   = make_fab_mask();

    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic [DATA_W-1:0] fabric;
        logic [DATA_W-1:0] ratio;
        logic              trig_prev;
    } regs_t;

    regs_t r_d, r_q;
    logic  trig_rise;

    always_comb begin
        r_d           = r_q;
        r_d.trig_prev = r_q.ctrl[TRIG_BIT];
        if (we_i) begin
            if (addr_i == ADDR_W'(CCD_ADDR_CTRL))
                r_d.ctrl = wdata_i & CTRL_MASK;
            else if (addr_i == ADDR_W'(CCD_ADDR_FABRIC))
                r_d.fabric = wdata_i & FAB_MASK;
            else if (addr_i == ADDR_W'(CCD_ADDR_RATIO))
                r_d.ratio = wdata_i & RATIO_MASK;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q.ctrl      <= '0;
            r_q.fabric    <= '0;
            r_q.ratio     <= RATIO_RST;
            r_q.trig_prev <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign trig_rise = r_q.ctrl[TRIG_BIT] && !r_q.trig_prev;

    for (genvar n = 0; n < NUM_CORES; n++) begin : g_core_fields
        assign hold_o[n]   = r_q.ctrl[HOLD_LSB + n];
        assign reload_o[n] = trig_rise && r_q.ctrl[RELOAD_LSB + n];
        assign ratio_o[n*CCD_RATIO_W +: CCD_RATIO_W] =
            r_q.ratio[n*FIELD_STRIDE +: CCD_RATIO_W];
    end

    always_comb begin
        if (addr_i == ADDR_W'(CCD_ADDR_CTRL))
            rdata_o = r_q.ctrl;
        else if (addr_i == ADDR_W'(CCD_ADDR_FABRIC))
            rdata_o = r_q.fabric;
        else if (addr_i == ADDR_W'(CCD_ADDR_RATIO))
            rdata_o = r_q.ratio;
        else if (addr_i == ADDR_W'(CCD_ADDR_STATUS))
            rdata_o = status_i;
        else
            rdata_o = '0;
    end

    // A trigger edge gives a reload request lasting a single cycle.
    assert_reload_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|reload_o) |=> !(|reload_o));

    // A reload request needs a trigger that was low in the previous cycle.
    assert_reload_on_rise_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|reload_o) |-> !$past(r_q.ctrl[TRIG_BIT]));

endmodule

// File: rtl/core_clk_div.sv
module core_clk_div
    import core_clk_div_pkg::*;
#(
    parameter int NUM_CORES    = 4,
    parameter int DATA_W       = 32,
    parameter int ADDR_W       = 5,
    parameter int FIELD_STRIDE = 8
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 bus_we_i,
    input  logic [ADDR_W-1:0]    bus_addr_i,
    input  logic [DATA_W-1:0]    bus_wdata_i,
    output logic [DATA_W-1:0]    bus_rdata_o,
    output logic [NUM_CORES-1:0] core_en_o
);

    localparam int PAD_W = CCD_RATIO_W - CCD_CNT_W;

    logic [NUM_CORES-1:0]             hold;
    logic [NUM_CORES-1:0]             reload;
    logic [NUM_CORES*CCD_RATIO_W-1:0] ratio;
    cnt_t                             active [NUM_CORES];
    logic [DATA_W-1:0]                status;

    core_clk_div_regs #(
        .NUM_CORES    (NUM_CORES),
        .DATA_W       (DATA_W),
        .ADDR_W       (ADDR_W),
        .FIELD_STRIDE (FIELD_STRIDE)
    ) u_regs (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .we_i     (bus_we_i),
        .addr_i   (bus_addr_i),
        .wdata_i  (bus_wdata_i),
        .status_i (status),
        .rdata_o  (bus_rdata_o),
        .hold_o   (hold),
        .reload_o (reload),
        .ratio_o  (ratio)
    );

    for (genvar n = 0; n < NUM_CORES; n++) begin : g_core
        core_clk_div_core u_div (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .hold_i   (hold[n]),
            .reload_i (reload[n]),
            .ratio_i  (ratio[n*CCD_RATIO_W +: CCD_RATIO_W]),
            .en_o     (core_en_o[n]),
            .active_o (active[n])
        );
    end

    always_comb begin
        status = '0;
        for (int n = 0; n < NUM_CORES; n++)
            status[n*FIELD_STRIDE +: CCD_RATIO_W] = {{PAD_W{1'b0}}, active[n]};
    end

endmodule

// File: tb/core_clk_div_tb.sv
module core_clk_div_tb;

    localparam int NC = 4;
    localparam logic [4:0] A_CTRL = 5'h00, A_FAB = 5'h08, A_RAT = 5'h0C, A_STAT = 5'h10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [NC-1:0] en;

    int vectors = 0;
    int fails   = 0;

    // Bench model of the expected state.
    int exp_act   [NC];
    int allow_old [NC];
    int req       [NC];
    logic [NC-1:0] hold_sh = '0;
    int gap  [NC];
    bit seen [NC];

    always #10 clk = ~clk;

    core_clk_div u_dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .bus_we_i    (we),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .core_en_o   (en)
    );

    function automatic int clamp(input int v);
        if (v == 0) return 1;
        if (v > 3) return 3;
        return v;
    endfunction

    function automatic logic [31:0] pack_status();
        logic [31:0] w = '0;
        for (int n = 0; n < NC; n++) w[n*8 +: 6] = 6'(exp_act[n]);
        return w;
    endfunction

    function automatic logic [31:0] pack_req();
        logic [31:0] w = '0;
        for (int n = 0; n < NC; n++) w[n*8 +: 6] = 6'(req[n]);
        return w;
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        #1;
        we = 1'b0;
        if (a == A_CTRL) hold_sh = d[8 +: NC];
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic check_status(input string tag);
        logic [31:0] d;
        rd(A_STAT, d);
        chk(d == pack_status(), tag, d, pack_status());
    endtask

    task automatic settle();
        for (int n = 0; n < NC; n++) allow_old[n] = exp_act[n];
    endtask

    // Stage req[] for the cores in mask, trigger, wait, check, and drop the trigger.
    task automatic apply(input logic [NC-1:0] mask, input int pre_wait);
        wr(A_RAT, pack_req());
        wr(A_CTRL, 32'(mask) << 20);
        repeat (pre_wait) @(posedge clk);
        wr(A_CTRL, (32'(mask) << 20) | 32'h0100_0000);
        for (int n = 0; n < NC; n++)
            if (mask[n]) begin
                allow_old[n] = exp_act[n];
                exp_act[n]   = clamp(req[n]);
            end
        repeat (12) @(posedge clk);
        check_status("R4/R5/R6 status after trigger");
        settle();
        wr(A_CTRL, 32'h0);
    endtask

    // Gap monitor: checks the spacing of enables against the expected ratios.
    always @(negedge clk) begin
        for (int n = 0; n < NC; n++) begin
            if (!rst_n || hold_sh[n]) begin
                seen[n] = 1'b0;
                gap[n]  = 0;
                if (rst_n) chk(en[n] == 1'b0, "R9 enable during hold", en[n], 0);
            end else begin
                gap[n]++;
                if (en[n]) begin
                    if (seen[n])
                        chk(gap[n] == exp_act[n] || gap[n] == allow_old[n],
                            "R3/R8 enable spacing", gap[n], exp_act[n]);
                    seen[n] = 1'b1;
                    gap[n]  = 0;
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int cnt;
        void'($urandom(32'd1729));
        for (int n = 0; n < NC; n++) begin
            exp_act[n] = 1; allow_old[n] = 1; req[n] = 1; gap[n] = 0; seen[n] = 0;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd(A_CTRL, d); chk(d == 32'h0, "R1 control reset", d, 0);
        rd(A_FAB, d);  chk(d == 32'h0, "R1 fabric reset", d, 0);
        rd(A_RAT, d);  chk(d == 32'h0101_0101, "R1 ratio reset", d, 32'h0101_0101);
        check_status("R1 status reset");

        // R2 write masks and unmapped addresses
        wr(A_CTRL, 32'hFFFF_FFFF);
        rd(A_CTRL, d); chk(d == 32'h01F0_FF00, "R2 control mask", d, 32'h01F0_FF00);
        wr(A_CTRL, 32'h0);
        wr(A_RAT, 32'hFFFF_FFFF);
        rd(A_RAT, d); chk(d == 32'h3F3F_3F3F, "R2 ratio mask", d, 32'h3F3F_3F3F);
        repeat (6) @(posedge clk);
        check_status("R7 ratio write without trigger");
        wr(A_FAB, 32'hFFFF_FFFF);
        rd(A_FAB, d); chk(d == 32'h003F_0000, "R2 fabric mask", d, 32'h003F_0000);
        wr(5'h04, 32'hFFFF_FFFF);
        rd(5'h04, d); chk(d == 32'h0, "R2 unmapped read", d, 0);
        rd(5'h14, d); chk(d == 32'h0, "R2 unmapped read high", d, 0);
        rd(A_CTRL, d); chk(d == 32'h0, "R2 unmapped write ignored", d, 0);
        wr(A_STAT, 32'h0);
        check_status("R11 status write ignored");

        // R4 clamp limits, directed
        req[0] = 0; req[1] = 63; req[2] = 2; req[3] = 4;
        apply(4'hF, 0);

        // R6 only core 1 selected
        req[0] = 3; req[1] = 1; req[2] = 3; req[3] = 3;
        apply(4'h2, 1);

        // Random stimulus: R4 R5 R6 R8
        for (int it = 0; it < 40; it++) begin
            for (int n = 0; n < NC; n++)
                req[n] = ($urandom_range(0, 5) == 0) ? int'($urandom_range(4, 63))
                                                     : int'($urandom_range(0, 3));
            apply(4'($urandom_range(0, 15)), int'($urandom_range(0, 5)));
        end

        // R7 trigger held high does not re-apply
        req[0] = 2; req[1] = 2; req[2] = 2; req[3] = 2;
        wr(A_RAT, pack_req());
        wr(A_CTRL, 32'h01F0_0000);
        for (int n = 0; n < NC; n++) begin allow_old[n] = exp_act[n]; exp_act[n] = 2; end
        repeat (12) @(posedge clk);
        check_status("R5 all cores to ratio 2");
        settle();
        req[0] = 3; req[1] = 1; req[2] = 3; req[3] = 1;
        wr(A_RAT, pack_req());
        wr(A_CTRL, 32'h0130_0000);
        repeat (12) @(posedge clk);
        check_status("R7 trigger held high");
        wr(A_CTRL, 32'h0);
        repeat (12) @(posedge clk);
        check_status("R7 trigger low");

        // R3 exact pulse count at ratio 3
        req[0] = 3; req[1] = 3; req[2] = 3; req[3] = 3;
        apply(4'hF, 2);
        repeat (6) @(posedge clk);
        cnt = 0;
        for (int c = 0; c < 30; c++) begin
            @(negedge clk);
            if (en[2]) cnt++;
        end
        chk(cnt == 10, "R3 ten pulses in thirty cycles", cnt, 10);

        // R3 ratio 1 keeps the enable high
        req[1] = 1;
        apply(4'h2, 0);
        cnt = 0;
        for (int c = 0; c < 9; c++) begin
            @(negedge clk);
            if (en[1]) cnt++;
        end
        chk(cnt == 9, "R3 ratio 1 always high", cnt, 9);

        // R9 hold on core 0, staged ratio applied during hold
        wr(A_CTRL, 32'h0000_0100);
        cnt = 0;
        for (int c = 0; c < 10; c++) begin
            @(negedge clk);
            if (en[2]) cnt++;
        end
        chk(cnt >= 3, "R9 other cores keep running", cnt, 3);
        req[0] = 2;
        wr(A_RAT, pack_req());
        wr(A_CTRL, 32'h0010_0100);
        wr(A_CTRL, 32'h0110_0100);
        allow_old[0] = 2; exp_act[0] = 2;
        repeat (3) @(posedge clk);
        check_status("R9 ratio applied during hold");
        wr(A_CTRL, 32'h0);
        repeat (12) @(posedge clk);

        // R10 fabric field has no effect
        wr(A_FAB, $urandom());
        repeat (12) @(posedge clk);
        check_status("R10 fabric write no effect");
        cnt = 0;
        for (int c = 0; c < 12; c++) begin
            @(negedge clk);
            if (en[0]) cnt++;
        end
        chk(cnt == 6, "R10 enables unchanged after fabric write", cnt, 6);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule